// File: doc/BRIEF.md
# Vectored Interrupt Response Sequencer

This block runs the hardware part of a CPU core's response to a maskable interrupt taken in vectored mode. When the core accepts an interrupt, the block captures the vector byte that the peripheral drives on the data bus and snapshots the core's registers. It then asks the core to drop both interrupt enable flags, saves the return address on the stack, reads the new program counter from a vector table and hands the new PC and stack pointer back to the core.

Two addressing modes are supported. The mode is selected by the core's linear-mode flag at acceptance. In the 16-bit compatible mode, two return bytes go to a stack that lives inside the 64 KB window selected by an 8-bit base register. The table entry is two bytes, located inside that same window. In the 24-bit linear mode, three return bytes go to the long stack, and the three-byte table entry is indexed by a 16-bit table register. The linear-mode flag itself is never written by this block.

All memory traffic is one byte per transfer over a request/ready handshake. The core holds off other work while `busy` is high.

Top module: `vec_irq_seq`

## Requirements
- R1: The vector byte on `data_in` and all register inputs (`adl`, `pc_in`, `i_in`, `mbase_in`, `sps_in`, `spl_in`) are captured on the rising edge where `irq_accept` is seen while idle. Later changes to these inputs have no effect on the sequence in progress.
- R2: `ief_clr` is high for exactly the one cycle after the accepting edge.
- R3: Compatible mode (`adl`=0) performs two writes (`mem_we`=1). The first write puts PC[15:8] at {MBASE, SPS-1} and the second puts PC[7:0] at {MBASE, SPS-2}. The 16-bit stack offset wraps modulo 2^16.
- R4: Compatible mode then performs two reads (`mem_we`=0) at {MBASE, ({I[7:0], vec} + k) mod 2^16} for k=0,1. Byte k becomes PC bits [8k+7:8k], and `pc_out` is {MBASE, fetched 16 bits}.
- R5: Linear mode (`adl`=1) performs three writes in this order: PC[23:16] at SPL-1, PC[15:8] at SPL-2, then PC[7:0] at SPL-3.
- R6: Linear mode then performs three reads at {I[15:0], vec} + k for k=0,1,2. The bytes are assembled little-endian into the full 24-bit `pc_out`.
- R7: After the last read there is a single commit cycle with `pc_we`=1. In that cycle either `sps_we`=1 with `sps_out`=SPS-2 (compatible mode) or `spl_we`=1 with `spl_out`=SPL-3 (linear mode), never both.
- R8: A transfer completes only on an edge where `mem_req` and `mem_rdy` are both high. While `mem_rdy` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R9: `done` is high for exactly the one cycle after the commit cycle. `busy` falls in the cycle after that.
- R10: `irq_accept` seen while `busy` is high is ignored: it starts nothing and produces no `ief_clr` or memory access.
- R11: After synchronous reset the block is idle: `busy`, `mem_req`, `pc_we`, `sps_we`, `spl_we`, `done` and `ief_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_accept | input | 1 | Core accepts a vectored maskable interrupt |
| data_in | input | 8 | Vector byte from the interrupting peripheral |
| adl | input | 1 | 1 = 24-bit linear mode, 0 = 16-bit compatible mode |
| pc_in | input | 24 | Current program counter (return address) |
| i_in | input | 16 | Vector table register |
| mbase_in | input | 8 | Compatible-mode window base |
| sps_in | input | 16 | Short stack pointer |
| spl_in | input | 24 | Long stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Transfer address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_rdy |
| mem_rdy | input | 1 | Transfer completes on this edge |
| ief_clr | output | 1 | Clear both interrupt enable flags |
| pc_we | output | 1 | Load pc_out into PC |
| pc_out | output | 24 | New program counter |
| sps_we | output | 1 | Load sps_out into short stack pointer |
| sps_out | output | 16 | New short stack pointer |
| spl_we | output | 1 | Load spl_out into long stack pointer |
| spl_out | output | 24 | New long stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |

## Verification
A wrong byte counter or a wrongly latched mode shows up at the very next transfer as a bad address, a bad write byte or a wrong direction. A wrong mode also shows up as a missing or extra transfer, which the per-transfer expectation queue reports at the point of mismatch. A corrupted PC assembly register stays hidden until the commit cycle, where `pc_out` differs from the table contents. A state machine that advances without `mem_rdy` moves the address while the bus is stalled, which is caught at the next stalled cycle. Late or spurious `done` and `ief_clr` pulses are checked in the exact cycle after commit and after acceptance.

// File: rtl/vis_pkg.sv
package vis_pkg;

    localparam int BYTE_W      = 8;
    localparam int SHORT_W     = 16;
    localparam int ADDR_W      = 24;
    localparam int LONG_BYTES  = ADDR_W / BYTE_W;
    localparam int SHORT_BYTES = SHORT_W / BYTE_W;
    localparam int IDX_W       = $clog2(LONG_BYTES + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_FETCH,
        ST_COMMIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic               linear;
        logic [BYTE_W-1:0]  vec;
        logic [ADDR_W-1:0]  pc;
        logic [SHORT_W-1:0] tbl;
        logic [BYTE_W-1:0]  mbase;
        logic [SHORT_W-1:0] sps;
        logic [ADDR_W-1:0]  spl;
    } irq_ctx_t;

    function automatic logic [IDX_W-1:0] xfer_count(input logic linear);
        return linear ? IDX_W'(LONG_BYTES) : IDX_W'(SHORT_BYTES);
    endfunction

    // stack address for the idx-th push (pre-decrement)
    function automatic logic [ADDR_W-1:0] push_addr(input irq_ctx_t c, input logic [IDX_W-1:0] idx);
        logic [SHORT_W-1:0] off16;
        off16 = c.sps - SHORT_W'(idx) - SHORT_W'(1);
        return c.linear ? (c.spl - ADDR_W'(idx) - ADDR_W'(1)) : {c.mbase, off16};
    endfunction

    // most significant byte first
    function automatic logic [BYTE_W-1:0] push_byte(input irq_ctx_t c, input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] sh;
        sh = xfer_count(c.linear) - idx - IDX_W'(1);
        return BYTE_W'(c.pc >> (BYTE_W * int'(sh)));
    endfunction

    function automatic logic [ADDR_W-1:0] table_addr(input irq_ctx_t c, input logic [IDX_W-1:0] idx);
        logic [SHORT_W-1:0] off16;
        off16 = {c.tbl[BYTE_W-1:0], c.vec} + SHORT_W'(idx);
        return c.linear ? ({c.tbl, c.vec} + ADDR_W'(idx)) : {c.mbase, off16};
    endfunction

endpackage

// File: rtl/vis_ctrl.sv
module vis_ctrl
    import vis_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             linear,
    input  logic             xfer,
    output seq_state_e       state,
    output logic [IDX_W-1:0] idx
);

    logic last;
    assign last = (idx == xfer_count(linear) - IDX_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_PUSH;
                    idx   <= '0;
                end
                ST_PUSH: if (xfer) begin
                    if (last) begin
                        state <= ST_FETCH;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_FETCH: if (xfer) begin
                    if (last) begin
                        state <= ST_COMMIT;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_COMMIT: state <= ST_DONE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // R8
    push_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PUSH && !xfer) |=> (state == ST_PUSH && $stable(idx)));

endmodule

// File: rtl/vis_pc_asm.sv
module vis_pc_asm
    import vis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] word
);

    for (genvar g = 0; g < LONG_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                word[g*BYTE_W +: BYTE_W] <= '0;
            end else if (load && idx == IDX_W'(g)) begin
                word[g*BYTE_W +: BYTE_W] <= rdata;
            end
        end
    end

endmodule

// File: rtl/vec_irq_seq.sv
module vec_irq_seq
    import vis_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_accept,
    input  logic [BYTE_W-1:0]  data_in,
    input  logic               adl,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [SHORT_W-1:0] i_in,
    input  logic [BYTE_W-1:0]  mbase_in,
    input  logic [SHORT_W-1:0] sps_in,
    input  logic [ADDR_W-1:0]  spl_in,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0]  mem_wdata,
    input  logic [BYTE_W-1:0]  mem_rdata,
    input  logic               mem_rdy,
    output logic               ief_clr,
    output logic               pc_we,
    output logic [ADDR_W-1:0]  pc_out,
    output logic               sps_we,
    output logic [SHORT_W-1:0] sps_out,
    output logic               spl_we,
    output logic [ADDR_W-1:0]  spl_out,
    output logic               busy,
    output logic               done
);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    irq_ctx_t          ctx_q;
    logic              start;
    logic              xfer;
    logic [ADDR_W-1:0] fetched;

    assign start = irq_accept && (state == ST_IDLE);
    assign xfer  = mem_req && mem_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q   <= '0;
            ief_clr <= 1'b0;
        end else begin
            ief_clr <= start;
            if (start) begin
                ctx_q <= '{linear: adl, vec: data_in, pc: pc_in, tbl: i_in,
                           mbase: mbase_in, sps: sps_in, spl: spl_in};
            end
        end
    end

    vis_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .linear (ctx_q.linear),
        .xfer   (xfer),
        .state  (state),
        .idx    (idx)
    );

    vis_pc_asm u_pc_asm (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .load  (xfer && state == ST_FETCH),
        .idx   (idx),
        .rdata (mem_rdata),
        .word  (fetched)
    );

    always_comb begin
        mem_req   = (state == ST_PUSH) || (state == ST_FETCH);
        mem_we    = (state == ST_PUSH);
        mem_addr  = (state == ST_PUSH) ? push_addr(ctx_q, idx) : table_addr(ctx_q, idx);
        mem_wdata = (state == ST_PUSH) ? push_byte(ctx_q, idx) : '0;
        pc_we     = (state == ST_COMMIT);
        pc_out    = ctx_q.linear ? fetched : {ctx_q.mbase, fetched[SHORT_W-1:0]};
        sps_we    = pc_we && !ctx_q.linear;
        sps_out   = ctx_q.sps - SHORT_W'(SHORT_BYTES);
        spl_we    = pc_we && ctx_q.linear;
        spl_out   = ctx_q.spl - ADDR_W'(LONG_BYTES);
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
    end

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pc_we |=> (done && !pc_we));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R2
    ief_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ief_clr |=> !ief_clr);

    // R7
    one_stack_chk: assert property (@(posedge clk) disable iff (rst)
        (sps_we || spl_we) |-> (pc_we && !(sps_we && spl_we)));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && irq_accept) |=> !ief_clr);

endmodule

// File: tb/vec_irq_seq_bench.sv
module vec_irq_seq_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        irq_accept = 1'b0;
    logic [7:0]  data_in = '0;
    logic        adl = 1'b0;
    logic [23:0] pc_in = '0;
    logic [15:0] i_in = '0;
    logic [7:0]  mbase_in = '0;
    logic [15:0] sps_in = '0;
    logic [23:0] spl_in = '0;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic        ief_clr, pc_we, sps_we, spl_we, busy, done;
    logic [23:0] pc_out, spl_out;
    logic [15:0] sps_out;

    vec_irq_seq u_vec_irq_seq (
        .clk(clk), .rst(rst), .irq_accept(irq_accept), .data_in(data_in), .adl(adl),
        .pc_in(pc_in), .i_in(i_in), .mbase_in(mbase_in), .sps_in(sps_in), .spl_in(spl_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .ief_clr(ief_clr), .pc_we(pc_we),
        .pc_out(pc_out), .sps_we(sps_we), .sps_out(sps_out), .spl_we(spl_we),
        .spl_out(spl_out), .busy(busy), .done(done)
    );

    typedef struct {
        logic [23:0] a;
        logic        we;
        logic [7:0]  d;
        string       tag;
    } txn_t;

    typedef struct {
        logic [23:0] pc;
        logic        sps_we;
        logic [15:0] sps;
        logic        spl_we;
        logic [23:0] spl;
        string       tag;
    } res_t;

    txn_t txq[$];
    res_t rsq[$];
    logic [7:0] mem [logic [23:0]];
    int n_chk = 0;
    int n_bad = 0;
    int rdy_mode = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: memory model, scoreboard pops, commit and done checks
    logic        prev_stall = 1'b0;
    logic [23:0] prev_a;
    logic        prev_we;
    logic [7:0]  prev_d;
    int          done_stage = 0;
    txn_t        mt;
    res_t        mr;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
        if (!rst) begin
            if (prev_stall)
                chk(mem_req && mem_addr == prev_a && mem_we == prev_we && mem_wdata == prev_d,
                    "R8", "held during stall", mem_addr, prev_a);
            mem_rdy = (rdy_mode == 0) ? 1'b1 : (cyc % 3 == 0);
            if (mem_req && mem_rdy) begin
                if (txq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected access", mem_addr, 0);
                end else begin
                    mt = txq.pop_front();
                    chk(mem_addr == mt.a && mem_we == mt.we, mt.tag, "access address", mem_addr, mt.a);
                    if (mt.we) begin
                        chk(mem_wdata == mt.d, mt.tag, "pushed byte", mem_wdata, mt.d);
                        mem[mem_addr] = mem_wdata;
                    end else begin
                        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
                    end
                end
            end
            prev_stall = mem_req && !mem_rdy;
            prev_a = mem_addr;
            prev_we = mem_we;
            prev_d = mem_wdata;
            if (done_stage == 1) begin
                chk(done == 1'b1, "R9", "done after commit", done, 1);
                done_stage = 2;
            end else if (done_stage == 2) begin
                chk(done == 1'b0 && busy == 1'b0, "R9", "done single cycle", done, 0);
                done_stage = 0;
            end
            if (pc_we) begin
                if (rsq.size() == 0) begin
                    chk(1'b0, "R7", "unexpected commit", pc_out, 0);
                end else begin
                    mr = rsq.pop_front();
                    chk(pc_out == mr.pc, mr.tag, "new pc", pc_out, mr.pc);
                    chk(sps_we == mr.sps_we && spl_we == mr.spl_we, "R7", "stack select",
                        {sps_we, spl_we}, {mr.sps_we, mr.spl_we});
                    if (mr.sps_we) chk(sps_out == mr.sps, "R7", "short sp", sps_out, mr.sps);
                    if (mr.spl_we) chk(spl_out == mr.spl, "R7", "long sp", spl_out, mr.spl);
                end
                done_stage = 1;
            end
        end
    end

    // driver: builds expectations from the requirements, then fires one interrupt
    task automatic run_seq(input bit lin, input logic [23:0] pc, input logic [15:0] iv,
                           input logic [7:0] mb, input logic [15:0] sps, input logic [23:0] spl,
                           input logic [7:0] vec, input logic [23:0] tgt, input int rmode,
                           input bit poke);
        int n;
        string rp, rf;
        res_t r;
        n  = lin ? 3 : 2;
        rp = lin ? "R5" : "R3";
        rf = lin ? "R6" : "R4";
        rdy_mode = rmode;
        for (int k = 0; k < n; k++) begin
            txn_t t;
            t.a   = lin ? spl - 24'(k + 1) : {mb, sps - 16'(k + 1)};
            t.we  = 1'b1;
            t.d   = 8'(pc >> (8 * (n - 1 - k)));
            t.tag = rp;
            txq.push_back(t);
        end
        for (int k = 0; k < n; k++) begin
            txn_t t;
            logic [15:0] o16;
            o16   = {iv[7:0], vec} + 16'(k);
            t.a   = lin ? {iv, vec} + 24'(k) : {mb, o16};
            t.we  = 1'b0;
            t.d   = 8'(tgt >> (8 * k));
            t.tag = rf;
            mem[t.a] = t.d;
            txq.push_back(t);
        end
        r.pc     = lin ? tgt : {mb, tgt[15:0]};
        r.sps_we = !lin;
        r.sps    = sps - 16'd2;
        r.spl_we = lin;
        r.spl    = spl - 24'd3;
        r.tag    = rf;
        rsq.push_back(r);

        @(negedge clk);
        adl = lin; pc_in = pc; i_in = iv; mbase_in = mb; sps_in = sps; spl_in = spl;
        data_in = vec; irq_accept = 1'b1;
        @(negedge clk);
        // R1: scramble every captured input right after acceptance
        irq_accept = 1'b0; data_in = ~vec; adl = ~lin; pc_in = ~pc; i_in = ~iv;
        mbase_in = ~mb; sps_in = ~sps; spl_in = ~spl;
        chk(ief_clr == 1'b1 && busy == 1'b1, "R2", "enable clear after accept", ief_clr, 1);
        @(negedge clk);
        chk(ief_clr == 1'b0, "R2", "enable clear single cycle", ief_clr, 0);
        if (poke) begin
            @(negedge clk);
            irq_accept = 1'b1; data_in = 8'h5A;
            @(negedge clk);
            irq_accept = 1'b0;
            chk(ief_clr == 1'b0, "R10", "no clear while busy", ief_clr, 0);
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req, "R10", "idle after done", busy, 0);
        chk(txq.size() == 0 && rsq.size() == 0, "R1", "all expected accesses seen", txq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !pc_we && !sps_we && !spl_we && !done && !ief_clr,
            "R11", "reset state", {busy, mem_req, pc_we, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req, "R11", "idle after reset release", busy, 0);
        // compatible, ready every cycle
        run_seq(1'b0, 24'hAB1234, 16'h7742, 8'h35, 16'h8000, 24'h0F0000, 8'h10, 24'h00C3D4, 0, 1'b0);
        // linear, stalled bus
        run_seq(1'b1, 24'h123456, 16'h4021, 8'h99, 16'h1000, 24'h200000, 8'h88, 24'h65F0E1, 1, 1'b0);
        // compatible, stack offset wraps below zero (R3)
        run_seq(1'b0, 24'h00BEEF, 16'h0030, 8'h07, 16'h0001, 24'h300000, 8'h20, 24'h00A55A, 1, 1'b0);
        // compatible, table offset wraps past 0xFFFF (R4)
        run_seq(1'b0, 24'h004321, 16'h11FF, 8'h0C, 16'h4000, 24'h300000, 8'hFF, 24'h007E81, 0, 1'b0);
        // linear with a second accept while busy (R10)
        run_seq(1'b1, 24'hFEDCBA, 16'hA0B0, 8'h00, 16'h2000, 24'h000100, 8'h04, 24'h13579B, 1, 1'b1);
        // compatible with a second accept while busy (R10)
        run_seq(1'b0, 24'h776655, 16'h0203, 8'h40, 16'h9000, 24'h500000, 8'h60, 24'h00F00D, 1, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule